// File: doc/BRIEF.md
# Streaming Dot Product and Scaling Unit

This block takes a signed scalar `a` and two fixed-length signed vectors X and Y. It produces the dot product X·Y and the scaled vector a·X. The scalar comes first, marked by a block-level strobe. The vector elements then stream in as X/Y pairs, and each side of a pair carries its own valid strobe. The block does not buffer the input vectors. Each accepted pair goes straight into a multiply-accumulate, and the product `a·x[i]` is written into an internal buffer.

After the last pair is accumulated, a one-cycle pulse on `dot_valid` marks the dot product as ready. The buffered scaled elements then leave one per cycle. Each one carries its own valid strobe and its own index. The dot-product pulse therefore comes well before the last scaled element.

End-to-end latency depends on how often pairs arrive, so downstream logic must use the strobes and not a fixed count. `ready` is high only while the block can accept a new scalar. It goes low from scalar acceptance until draining ends.

The controller has three states:
- IDLE: waiting for a scalar.
- COLLECT: accepting pairs.
- DRAIN: emitting scaled elements.

It has four transitions:
- IDLE→COLLECT (scalar accepted).
- COLLECT→COLLECT (pair accepted, not last).
- COLLECT→DRAIN (last pair accepted).
- DRAIN→IDLE (last scaled element emitted).

Top module: `dotscale_unit`

## Requirements
- R1: After reset, `ready` is 1, `dot_valid` is 0 and `sx_valid` is 0.
- R2: A scalar is accepted only when `scal_valid` and `ready` are both high. `scal_valid` while `ready` is low has no effect on any result.
- R3: A pair is accepted only in COLLECT and only on a cycle where `x_valid` and `y_valid` are both high. A lone `x_valid` or `y_valid`, or a pair offered while `ready` is high, is ignored.
- R4: `dot_out` is the exact signed 36-bit sum of the 10 signed 16-bit products x[i]·y[i]. Full-scale operands do not overflow.
- R5: `dot_valid` is a single-cycle pulse. It is visible in the cycle right after the edge that accepts the 10th pair, and never earlier, however sparse the arrivals.
- R6: Starting in the cycle after the `dot_valid` pulse, `sx_valid` is high for exactly 10 consecutive cycles. `sx_index` counts 0 to 9 in order, and `sx_out` is the signed 32-bit product a·x[sx_index].
- R7: `ready` falls in the cycle after a scalar is accepted. It is low while `dot_valid` is high. It is high again in the cycle after the last scaled element, so a new vector can start.
- R8: Acceptance of a scalar clears the accumulator, so `dot_out` reads 0 in the following cycle. While `ready` is high and no scalar is offered, `dot_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scal_valid | input | 1 | Scalar strobe |
| scal_in | input | 16 | Signed scalar a |
| x_valid | input | 1 | X element strobe |
| x_in | input | 16 | Signed X element |
| y_valid | input | 1 | Y element strobe |
| y_in | input | 16 | Signed Y element |
| ready | output | 1 | High while a new scalar may be accepted |
| dot_valid | output | 1 | One-cycle pulse: dot product ready |
| dot_out | output | 36 | Signed dot product |
| sx_valid | output | 1 | Scaled element strobe |
| sx_index | output | 4 | Index of the scaled element |
| sx_out | output | 32 | Signed scaled element a·x[i] |

## Verification
The bench streams vectors with pairs on every cycle and also with idle gaps. During the gaps it holds only one side's strobe high. A design that accepted half-pairs would shift every later element and corrupt both results. Scalars are offered during collection and during draining: a design that let them in would rescale the output or restart the count.

Full-scale negative operands check the accumulator width; a narrow sum would wrap negative. The bench also checks the exact cycle of the dot pulse and of each scaled element, so an off-by-one in the counters or a pulse that fires early under sparse input shows up as a miscompare.

// File: rtl/dotscale_pkg.sv
package dotscale_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2
    } dsu_state_e;
endpackage

// File: rtl/dotscale_ctrl.sv
module dotscale_ctrl
    import dotscale_pkg::*;
#(
    parameter int VEC_LEN = 10,
    localparam int IDX_W  = $clog2(VEC_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scal_valid,
    input  logic             x_valid,
    input  logic             y_valid,
    output logic             is_idle,
    output logic             load_scal,
    output logic             pair_acc,
    output logic             last_pair,
    output logic [IDX_W-1:0] wr_idx,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

    dsu_state_e       state_q, state_d;
    logic [IDX_W-1:0] wr_q, rd_q;
    logic             last_drain;

    // state register and element counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load_scal)
                wr_q <= '0;
            else if (pair_acc)
                wr_q <= last_pair ? '0 : wr_q + 1'b1;
            if (rd_en)
                rd_q <= last_drain ? '0 : rd_q + 1'b1;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        load_scal  = 1'b0;
        pair_acc   = 1'b0;
        last_pair  = 1'b0;
        rd_en      = 1'b0;
        last_drain = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (scal_valid) begin
                    load_scal = 1'b1;
                    state_d   = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (x_valid && y_valid) begin
                    pair_acc = 1'b1;
                    if (wr_q == LAST_IDX) begin
                        last_pair = 1'b1;
                        state_d   = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                rd_en = 1'b1;
                if (rd_q == LAST_IDX) begin
                    last_drain = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign is_idle = (state_q == ST_IDLE);
    assign wr_idx  = wr_q;
    assign rd_idx  = rd_q;
endmodule

// File: rtl/dotscale_mac.sv
module dotscale_mac #(
    parameter int DATA_W = 16,
    parameter int PROD_W = 2 * DATA_W,
    parameter int ACC_W  = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] y_in,
    output logic signed [ACC_W-1:0]  acc
);
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod     = PROD_W'(x_in) * PROD_W'(y_in);
    assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (en)
            acc <= acc + prod_ext;
    end
endmodule

// File: rtl/dotscale_sbuf.sv
module dotscale_sbuf #(
    parameter int VEC_LEN = 10,
    parameter int DATA_W  = 16,
    parameter int PROD_W  = 2 * DATA_W,
    localparam int IDX_W  = $clog2(VEC_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_scal,
    input  logic signed [DATA_W-1:0] scal_in,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_index,
    output logic signed [PROD_W-1:0] out_data
);
    logic signed [DATA_W-1:0] scale_q;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] mem [VEC_LEN];

    assign scaled = PROD_W'(scale_q) * PROD_W'(x_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scale_q <= '0;
        else if (load_scal)
            scale_q <= scal_in;
    end

    for (genvar g = 0; g < VEC_LEN; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                mem[g] <= scaled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_index <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_en;
            if (rd_en) begin
                out_index <= rd_idx;
                out_data  <= mem[rd_idx];
            end
        end
    end
endmodule

// File: rtl/dotscale_unit.sv
module dotscale_unit #(
    parameter int VEC_LEN = 10,
    parameter int DATA_W  = 16,
    localparam int PROD_W = 2 * DATA_W,
    localparam int ACC_W  = PROD_W + $clog2(VEC_LEN),
    localparam int IDX_W  = $clog2(VEC_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scal_valid,
    input  logic signed [DATA_W-1:0] scal_in,
    input  logic                     x_valid,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic                     y_valid,
    input  logic signed [DATA_W-1:0] y_in,
    output logic                     ready,
    output logic                     dot_valid,
    output logic signed [ACC_W-1:0]  dot_out,
    output logic                     sx_valid,
    output logic [IDX_W-1:0]         sx_index,
    output logic signed [PROD_W-1:0] sx_out
);
    logic             load_scal, pair_acc, last_pair, rd_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    dotscale_ctrl #(.VEC_LEN(VEC_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scal_valid(scal_valid),
        .x_valid   (x_valid),
        .y_valid   (y_valid),
        .is_idle   (ready),
        .load_scal (load_scal),
        .pair_acc  (pair_acc),
        .last_pair (last_pair),
        .wr_idx    (wr_idx),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx)
    );

    dotscale_mac #(.DATA_W(DATA_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load_scal),
        .en   (pair_acc),
        .x_in (x_in),
        .y_in (y_in),
        .acc  (dot_out)
    );

    dotscale_sbuf #(.VEC_LEN(VEC_LEN), .DATA_W(DATA_W), .PROD_W(PROD_W)) u_sbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_scal(load_scal),
        .scal_in  (scal_in),
        .wr_en    (pair_acc),
        .wr_idx   (wr_idx),
        .x_in     (x_in),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .out_valid(sx_valid),
        .out_index(sx_index),
        .out_data (sx_out)
    );

    // dot-product ready pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dot_valid <= 1'b0;
        else
            dot_valid <= last_pair;
    end
endmodule

// File: rtl/dotscale_unit_chk.sv
module dotscale_unit_chk #(
    parameter int VEC_LEN = 10,
    parameter int ACC_W   = 36,
    localparam int IDX_W  = $clog2(VEC_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scal_valid,
    input logic             ready,
    input logic             dot_valid,
    input logic [ACC_W-1:0] dot_out,
    input logic             sx_valid,
    input logic [IDX_W-1:0] sx_index
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ready && !dot_valid && !sx_valid));

    a_r5_dot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid |=> !dot_valid);

    a_r6_first_after_dot: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid |=> (sx_valid && sx_index == '0));

    a_r6_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (sx_valid && sx_index != LAST_IDX) |=>
            (sx_valid && sx_index == IDX_W'($past(sx_index) + 1'b1)));

    a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (sx_valid && sx_index == LAST_IDX) |=> !sx_valid);

    a_r7_busy_after_scalar: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && scal_valid) |=> !ready);

    a_r7_busy_at_dot: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid |-> !ready);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !scal_valid) |=> $stable(dot_out));
endmodule

bind dotscale_unit dotscale_unit_chk #(.VEC_LEN(VEC_LEN), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scal_valid(scal_valid),
    .ready     (ready),
    .dot_valid (dot_valid),
    .dot_out   (dot_out),
    .sx_valid  (sx_valid),
    .sx_index  (sx_index)
);

// File: tb/dotscale_unit_tb.sv
module dotscale_unit_tb;
    localparam int CLK_P = 10;
    localparam int N     = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               scal_valid = 1'b0, x_valid = 1'b0, y_valid = 1'b0;
    logic signed [15:0] scal_in = '0, x_in = '0, y_in = '0;
    logic               ready, dot_valid, sx_valid;
    logic signed [35:0] dot_out;
    logic [3:0]         sx_index;
    logic signed [31:0] sx_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic signed [15:0] vx [N];
    logic signed [15:0] vy [N];

    always #(CLK_P/2) clk = ~clk;

    dotscale_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .scal_valid(scal_valid), .scal_in(scal_in),
        .x_valid(x_valid), .x_in(x_in),
        .y_valid(y_valid), .y_in(y_in),
        .ready(ready), .dot_valid(dot_valid), .dot_out(dot_out),
        .sx_valid(sx_valid), .sx_index(sx_index), .sx_out(sx_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one full vector: scalar, pairs (with optional gaps), then dot and drain checks
    task automatic run_vec(input logic signed [15:0] a, input int gap, input bit inject);
        longint exp_dot = 0;
        bit     early   = 1'b0;
        for (int i = 0; i < N; i++) exp_dot += longint'(vx[i]) * longint'(vy[i]);
        chk(ready == 1'b1, "R7", "ready before scalar", ready, 1);
        scal_valid = 1'b1; scal_in = a;
        step();
        scal_valid = 1'b0;
        chk(ready == 1'b0, "R7", "ready after scalar", ready, 0);
        chk(dot_out == 0, "R8", "dot cleared on scalar", dot_out, 0);
        for (int i = 0; i < N; i++) begin
            for (int g = 0; g < gap; g++) begin
                x_valid = (g % 2 == 0); y_valid = (g % 2 != 0);
                x_in = 16'sd1234; y_in = -16'sd999;
                if (inject) begin scal_valid = 1'b1; scal_in = 16'sd77; end
                step();
                if (dot_valid) early = 1'b1;
            end
            scal_valid = 1'b0;
            x_valid = 1'b1; y_valid = 1'b1; x_in = vx[i]; y_in = vy[i];
            step();
            x_valid = 1'b0; y_valid = 1'b0;
            if (i < N-1 && dot_valid) early = 1'b1;
        end
        chk(!early, "R5", "no early dot_valid", early, 0);
        @(negedge clk);
        chk(dot_valid == 1'b1, "R5", "dot_valid after last pair", dot_valid, 1);
        chk(dot_out == exp_dot, "R4", "dot product", dot_out, exp_dot);
        chk(ready == 1'b0, "R7", "ready low at dot", ready, 0);
        for (int i = 0; i < N; i++) begin
            longint exp_sx = longint'(a) * longint'(vx[i]);
            @(posedge clk);
            @(negedge clk);
            chk(sx_valid == 1'b1 && sx_index == 4'(i), "R6", "sx strobe/index",
                {sx_valid, sx_index}, {1'b1, 4'(i)});
            chk(sx_out == exp_sx, inject ? "R2" : "R6", "sx value", sx_out, exp_sx);
            if (i == 0) chk(dot_valid == 1'b0, "R5", "dot pulse width", dot_valid, 0);
            if (inject && i < N-2) begin scal_valid = 1'b1; scal_in = 16'sd55; end
            else scal_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(sx_valid == 1'b0, "R6", "sx stops after 10", sx_valid, 0);
        chk(ready == 1'b1, "R7", "ready after drain", ready, 1);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ready == 1'b1, "R1", "ready at reset", ready, 1);
        chk(dot_valid == 1'b0, "R1", "dot_valid at reset", dot_valid, 0);
        chk(sx_valid == 1'b0, "R1", "sx_valid at reset", sx_valid, 0);
    endtask

    task automatic t_dense();
        for (int i = 0; i < N; i++) begin
            vx[i] = 16'(i * 37 - 150);
            vy[i] = 16'(300 - i * 71);
        end
        run_vec(16'sd3, 0, 1'b0);
    endtask

    task automatic t_sparse();
        for (int i = 0; i < N; i++) begin
            vx[i] = 16'(i * 1111 - 5000);
            vy[i] = 16'((i % 3) * 2000 - 1500);
        end
        run_vec(-16'sd12, 2, 1'b1);
    endtask

    task automatic t_extreme();
        for (int i = 0; i < N; i++) begin
            vx[i] = -16'sd32768;
            vy[i] = -16'sd32768;
        end
        run_vec(-16'sd32768, 1, 1'b0);
        for (int i = 0; i < N; i++) begin
            vx[i] = 16'sd32767;
            vy[i] = -16'sd32768;
        end
        run_vec(16'sd32767, 0, 1'b0);
    endtask

    // pairs while idle must not touch the held result (R3, R8)
    task automatic t_idle_pairs();
        logic signed [35:0] held;
        @(negedge clk);
        held = dot_out;
        x_valid = 1'b1; y_valid = 1'b1; x_in = 16'sd500; y_in = 16'sd500;
        repeat (3) @(negedge clk);
        x_valid = 1'b0; y_valid = 1'b0;
        chk(dot_out == held, "R3", "idle pair ignored", dot_out, held);
        chk(dot_out == held, "R8", "dot held while idle", dot_out, held);
        chk(sx_valid == 1'b0 && dot_valid == 1'b0, "R3", "no output from idle pair",
            {sx_valid, dot_valid}, 0);
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        #1;
        t_dense();
        t_sparse();
        t_idle_pairs();
        t_extreme();
        t_dense();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule